// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that runs down in two back-to-back stages, each timed from its own preload value. A stage lasts the preload times a power-of-two number of reference-clock cycles. The power is chosen by a scale select: a coarse shift of 15 or a fine shift of 5. When the first stage runs out, the block pulses either a normal interrupt or a system-management interrupt, as selected, and goes straight on into the second stage. When the second stage runs out and reboot is enabled, it pulses a reset request and sets a sticky flag that records a watchdog reboot. In free-running mode it then starts the first stage again. Otherwise it stays idle until it is next refreshed.

Software keeps the timer from firing by pulsing the keep-alive input, or by taking enable low and then high again. Either one restarts the countdown at the first stage. The previous-reboot flag has its own power-on reset, so the watchdog's own reset leaves it alone. Register decoding, bus access and the actual system reset belong to the surrounding logic.

Top module: `wdt_two_stage`

## Requirements
- R1: While rst_ni is low and just after it is released with enable_i low, running_o, stage_two_o, irq_o, smi_o and reset_req_o are all 0.
- R2: A stage loaded with preload value P lasts max(P,1) × 2^15 clock cycles when fast_scale_i is 0, and max(P,1) × 2^5 when it is 1. Its expiry is registered on the edge that lies that many edges after the load edge.
- R3: When stage one expires, a pulse lasting exactly one cycle appears on irq_o if int_sel_i is 0, or on smi_o if int_sel_i is 1. Stage two is loaded on the same edge, so stage_two_o reads 1.
- R4: When stage two expires with reboot_en_i at 1, reset_req_o pulses for exactly one cycle and prev_reboot_o becomes 1 on the same edge.
- R5: When stage two expires with reboot_en_i at 0, reset_req_o stays 0 and prev_reboot_o does not change.
- R6: After stage two expires, the timer reloads stage one if free_run_i is 1. If free_run_i is 0 it goes idle, with running_o at 0.
- R7: A keep-alive pulse (kick_i high while enable_i is high) restarts stage one with a full count, from either stage.
- R8: While enable_i is low the timer is stopped (running_o is 0 one edge later), and kick_i has no effect.
- R9: prev_reboot_o is unaffected by rst_ni. It is cleared only by flag_clr_i or by por_ni.
- R10: A preload value is sampled on the edge that loads its stage. Changes made to it during that stage do not alter the stage's length.
- R11: A 0 to 1 transition of enable_i restarts stage one with a full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous watchdog reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the reboot flag |
| enable_i | input | 1 | Timer enable |
| free_run_i | input | 1 | Restart stage one after stage two expires |
| reboot_en_i | input | 1 | Allow a reset request when stage two expires |
| fast_scale_i | input | 1 | 1: shift of 5, 0: shift of 15 |
| int_sel_i | input | 1 | Stage-one interrupt type: 0 normal IRQ, 1 SMI |
| preload_one_i | input | PRELOAD_W | Stage-one preload |
| preload_two_i | input | PRELOAD_W | Stage-two preload |
| kick_i | input | 1 | Keep-alive pulse |
| flag_clr_i | input | 1 | Clear the previous-reboot flag |
| irq_o | output | 1 | One-cycle normal interrupt at stage-one expiry |
| smi_o | output | 1 | One-cycle SMI at stage-one expiry |
| reset_req_o | output | 1 | One-cycle reset request at stage-two expiry |
| prev_reboot_o | output | 1 | Sticky flag: a watchdog reboot occurred |
| running_o | output | 1 | Countdown active |
| stage_two_o | output | 1 | Countdown is in stage two |

## Verification
The countdown is run with each combination of reboot-enable, free-run and interrupt type that leads to a different outcome. A run with reboot on and free-run off must produce exactly one interrupt, one reset request and then idle. A run with reboot off and free-run on must produce a repeating series of SMIs and no reset request. Preloads of 0, 1, 2 and 3, under both scales, show whether the scale shift and the zero-preload floor are applied. Keep-alive pulses in each stage, a one-cycle drop of enable, and preload changes made mid-stage show whether a restart really reloads stage one and whether the preloads are sampled only on the load edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {STG_ONE = 1'b0, STG_TWO = 1'b1} stage_e;
  typedef enum logic {INT_IRQ = 1'b0, INT_SMI = 1'b1} int_sel_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int PW = SLOW_SHIFT;
  localparam logic [PW-1:0] SLOW_LAST = {PW{1'b1}};
  localparam logic [PW-1:0] FAST_LAST = PW'((1 << FAST_SHIFT) - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last_val;

  assign last_val = fast_i ? FAST_LAST : SLOW_LAST;
  // >= so that a scale change mid-stage cannot skip the wrap point
  assign tick_o   = run_i && (pre_q >= last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else if (run_i)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [PRELOAD_W-1:0] load_val_i,
  input  logic                 tick_i,
  output logic                 last_o
);
  logic [PRELOAD_W-1:0] cnt_q;

  // zero preload behaves as one unit
  assign last_o = (cnt_q <= PRELOAD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '1;
    else if (load_i)            cnt_q <= load_val_i;
    else if (tick_i && !last_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_sticky_flag.sv
module wdt_sticky_flag (
  input  logic clk_i,
  input  logic por_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 por_ni,
  input  logic                 enable_i,
  input  logic                 free_run_i,
  input  logic                 reboot_en_i,
  input  logic                 fast_scale_i,
  input  logic                 int_sel_i,
  input  logic [PRELOAD_W-1:0] preload_one_i,
  input  logic [PRELOAD_W-1:0] preload_two_i,
  input  logic                 kick_i,
  input  logic                 flag_clr_i,
  output logic                 irq_o,
  output logic                 smi_o,
  output logic                 reset_req_o,
  output logic                 prev_reboot_o,
  output logic                 running_o,
  output logic                 stage_two_o
);
  logic   enable_q, running_q;
  stage_e stage_q;
  logic   irq_q, smi_q, rreq_q;
  logic   tick, last, expire, expire_one, expire_two;
  logic   start_one, load_one, load_two, load_any;
  logic [PRELOAD_W-1:0] load_val;

  // restart requests outrank an expiry on the same edge
  assign start_one  = enable_i && (kick_i || !enable_q);
  assign expire     = running_q && tick && last && enable_i && !start_one;
  assign expire_one = expire && (stage_q == STG_ONE);
  assign expire_two = expire && (stage_q == STG_TWO);
  assign load_one   = start_one || (expire_two && free_run_i);
  assign load_two   = expire_one;
  assign load_any   = load_one || load_two;
  assign load_val   = load_one ? preload_one_i : preload_two_i;

  wdt_prescale #(
    .SLOW_SHIFT(SLOW_SHIFT),
    .FAST_SHIFT(FAST_SHIFT)
  ) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load_any),
    .run_i  (running_q),
    .fast_i (fast_scale_i),
    .tick_o (tick)
  );

  wdt_down_counter #(
    .PRELOAD_W(PRELOAD_W)
  ) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_any),
    .load_val_i(load_val),
    .tick_i    (tick),
    .last_o    (last)
  );

  wdt_sticky_flag u_flag (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .set_i (expire_two && reboot_en_i),
    .clr_i (flag_clr_i),
    .flag_o(prev_reboot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q  <= 1'b0;
      running_q <= 1'b0;
      stage_q   <= STG_ONE;
      irq_q     <= 1'b0;
      smi_q     <= 1'b0;
      rreq_q    <= 1'b0;
    end else begin
      enable_q <= enable_i;
      irq_q    <= expire_one && (int_sel_e'(int_sel_i) == INT_IRQ);
      smi_q    <= expire_one && (int_sel_e'(int_sel_i) == INT_SMI);
      rreq_q   <= expire_two && reboot_en_i;
      if (!enable_i) begin
        running_q <= 1'b0;
        stage_q   <= STG_ONE;
      end else if (load_one) begin
        running_q <= 1'b1;
        stage_q   <= STG_ONE;
      end else if (load_two) begin
        stage_q   <= STG_TWO;
      end else if (expire_two) begin
        running_q <= 1'b0;
        stage_q   <= STG_ONE;
      end
    end
  end

  assign irq_o       = irq_q;
  assign smi_o       = smi_q;
  assign reset_req_o = rreq_q;
  assign running_o   = running_q;
  assign stage_two_o = running_q && (stage_q == STG_TWO);
endmodule

// File: rtl/wdt_two_stage_checker.sv
module wdt_two_stage_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic enable_i,
  input logic kick_i,
  input logic reboot_en_i,
  input logic flag_clr_i,
  input logic irq_o,
  input logic smi_o,
  input logic reset_req_o,
  input logic prev_reboot_o,
  input logic running_o,
  input logic stage_two_o
);
  assert_one_int_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(irq_o && smi_o));

  assert_int_enters_two_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (irq_o || smi_o) |-> (running_o && stage_two_o));

  assert_int_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (irq_o || smi_o) |=> !(irq_o || smi_o));

  assert_req_sets_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    reset_req_o |-> prev_reboot_o);

  assert_req_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    reset_req_o |-> $past(reboot_en_i));

  assert_kick_restarts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (enable_i && kick_i) |=> (running_o && !stage_two_o));

  assert_disable_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !enable_i |=> !running_o);

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    $fell(prev_reboot_o) |-> $past(flag_clr_i));
endmodule

bind wdt_two_stage wdt_two_stage_checker u_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_ni       (por_ni),
  .enable_i     (enable_i),
  .kick_i       (kick_i),
  .reboot_en_i  (reboot_en_i),
  .flag_clr_i   (flag_clr_i),
  .irq_o        (irq_o),
  .smi_o        (smi_o),
  .reset_req_o  (reset_req_o),
  .prev_reboot_o(prev_reboot_o),
  .running_o    (running_o),
  .stage_two_o  (stage_two_o)
);

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  localparam int PW = 20;
  localparam int K_IRQ = 0;
  localparam int K_SMI = 1;
  localparam int K_RST = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0;
  logic enable_i = 1'b0, free_run_i = 1'b0, reboot_en_i = 1'b1;
  logic fast_scale_i = 1'b1, int_sel_i = 1'b0, kick_i = 1'b0, flag_clr_i = 1'b0;
  logic [PW-1:0] preload_one_i = '0, preload_two_i = '0;
  logic irq_o, smi_o, reset_req_o, prev_reboot_o, running_o, stage_two_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int t0, t1, t2;
  bit done = 1'b0;
  int q_cyc[$];
  int q_kind[$];
  string q_req[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  wdt_two_stage #(.PRELOAD_W(PW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .enable_i(enable_i),
    .free_run_i(free_run_i), .reboot_en_i(reboot_en_i), .fast_scale_i(fast_scale_i),
    .int_sel_i(int_sel_i), .preload_one_i(preload_one_i), .preload_two_i(preload_two_i),
    .kick_i(kick_i), .flag_clr_i(flag_clr_i), .irq_o(irq_o), .smi_o(smi_o),
    .reset_req_o(reset_req_o), .prev_reboot_o(prev_reboot_o), .running_o(running_o),
    .stage_two_o(stage_two_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int k, input string req);
    q_cyc.push_back(c);
    q_kind.push_back(k);
    q_req.push_back(req);
  endtask

  task automatic observe(input int k);
    int ec, ek;
    string er;
    if (q_cyc.size() == 0) begin
      chk(1'b0, "R8", "unexpected pulse kind", k, -1);
    end else begin
      ec = q_cyc.pop_front();
      ek = q_kind.pop_front();
      er = q_req.pop_front();
      chk(ek == k, er, "pulse kind", k, ek);
      chk(ec == cyc, er, "pulse cycle", cyc, ec);
    end
  endtask

  // monitor: scoreboard pops one expected item per observed pulse
  always @(negedge clk_i) begin
    if (rst_ni && por_ni && !done) begin
      if (irq_o) observe(K_IRQ);
      if (smi_o) observe(K_SMI);
      if (reset_req_o) observe(K_RST);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    idle(1);
    flag_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    idle(3);
    por_ni = 1'b1;
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state
    chk(!running_o && !stage_two_o, "R1", "idle after reset", running_o, 0);
    chk(!irq_o && !smi_o && !reset_req_o, "R1", "no pulses after reset", reset_req_o, 0);
    chk(!prev_reboot_o, "R9", "flag after por", prev_reboot_o, 0);

    // IRQ, reboot on, free-run off
    preload_one_i = 3; preload_two_i = 2; int_sel_i = 0;
    reboot_en_i = 1; free_run_i = 0; fast_scale_i = 1; enable_i = 1;
    t0 = cyc + 1;
    push(t0 + 96, K_IRQ, "R3");
    push(t0 + 160, K_RST, "R4");
    wait_cyc(t0 + 97);
    chk(stage_two_o == 1'b1, "R3", "stage two after irq", stage_two_o, 1);
    wait_cyc(t0 + 161);
    chk(prev_reboot_o == 1'b1, "R4", "flag after reboot", prev_reboot_o, 1);
    chk(running_o == 1'b0, "R6", "idle without free-run", running_o, 0);
    idle(5);
    chk(q_cyc.size() == 0, "R2", "pending events", q_cyc.size(), 0);

    // watchdog reset leaves flag
    enable_i = 0;
    idle(1);
    rst_ni = 0;
    idle(2);
    rst_ni = 1;
    idle(1);
    chk(prev_reboot_o == 1'b1, "R9", "flag kept over rst_ni", prev_reboot_o, 1);
    chk(running_o == 1'b0, "R1", "idle after rst_ni", running_o, 0);
    clear_flag();
    chk(prev_reboot_o == 1'b0, "R9", "flag cleared", prev_reboot_o, 0);

    // SMI, reboot off, free-run on
    int_sel_i = 1; reboot_en_i = 0; free_run_i = 1;
    preload_one_i = 2; preload_two_i = 1; enable_i = 1;
    t0 = cyc + 1;
    push(t0 + 64, K_SMI, "R3");
    push(t0 + 160, K_SMI, "R6");
    wait_cyc(t0 + 161);
    chk(prev_reboot_o == 1'b0, "R5", "flag untouched", prev_reboot_o, 0);
    chk(running_o == 1'b1, "R6", "free-run restarted", running_o, 1);
    enable_i = 0;
    idle(1);
    chk(running_o == 1'b0, "R8", "disable stops", running_o, 0);

    // kick while disabled is ignored
    kick_i = 1;
    idle(3);
    kick_i = 0;
    idle(200);
    chk(running_o == 1'b0, "R8", "kick ignored when disabled", running_o, 0);

    // keep-alive in both stages
    int_sel_i = 0; reboot_en_i = 1; free_run_i = 0;
    preload_one_i = 2; preload_two_i = 2; enable_i = 1;
    t0 = cyc + 1;
    wait_cyc(t0 + 40);
    kick_i = 1;
    t1 = cyc + 1;
    idle(1);
    kick_i = 0;
    push(t1 + 64, K_IRQ, "R7");
    wait_cyc(t1 + 74);
    chk(stage_two_o == 1'b1, "R7", "in stage two", stage_two_o, 1);
    kick_i = 1;
    t2 = cyc + 1;
    idle(1);
    kick_i = 0;
    chk(running_o && !stage_two_o, "R7", "kick returns to stage one", stage_two_o, 0);
    push(t2 + 64, K_IRQ, "R7");
    push(t2 + 128, K_RST, "R7");
    wait_cyc(t2 + 129);
    chk(prev_reboot_o == 1'b1, "R4", "flag after reboot", prev_reboot_o, 1);
    enable_i = 0;
    clear_flag();

    // preload sampled at load
    preload_one_i = 2; preload_two_i = 1; enable_i = 1;
    t0 = cyc + 1;
    push(t0 + 64, K_IRQ, "R10");
    push(t0 + 96, K_RST, "R10");
    idle(10);
    preload_one_i = 5;
    wait_cyc(t0 + 70);
    preload_two_i = 7;
    wait_cyc(t0 + 97);
    enable_i = 0;
    clear_flag();

    // zero preload acts as one
    preload_one_i = 0; reboot_en_i = 0; enable_i = 1;
    t0 = cyc + 1;
    push(t0 + 32, K_IRQ, "R2");
    wait_cyc(t0 + 33);
    enable_i = 0;
    idle(2);

    // enable rising edge restarts
    preload_one_i = 2; enable_i = 1;
    t0 = cyc + 1;
    wait_cyc(t0 + 40);
    enable_i = 0;
    idle(1);
    enable_i = 1;
    t1 = cyc + 1;
    push(t1 + 64, K_IRQ, "R11");
    wait_cyc(t1 + 65);
    enable_i = 0;
    idle(2);

    // slow scale
    fast_scale_i = 0; preload_one_i = 1; enable_i = 1;
    t0 = cyc + 1;
    push(t0 + 32768, K_IRQ, "R2");
    wait_cyc(t0 + 32769);
    enable_i = 0;
    idle(10);
    chk(q_cyc.size() == 0, "R2", "pending events at end", q_cyc.size(), 0);
    finish_run();
  end
endmodule